// File: doc/BRIEF.md
# NAND block Hamming ECC engine

This engine sits beside the byte-wide data path of a NAND flash controller and builds a Hamming code over each 512-byte block of a page as the bytes go by. A read or write command to an address whose low nine bits are zero arms the engine. The engine then folds every transferred byte into a running parity word. Each time a block fills, or when the access sequencer flags the last transfer of the page, the code for that block is latched into its own slot. Up to four slots are kept, which covers a 2048-byte page.

On a write, the controller takes the slot contents from `code_o` and places them in the spare area after the data. On a read, the controller streams the codes it reads back from the spare area into the check port, one per block. For each block the engine forms the syndrome and records a two-bit status. For a correctable error it also reports the byte and bit that flipped, so software can repair the buffer.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset `busy_o` is 0, every code slot in `code_o` is zero, every status field is 0, and `err_byte_o`/`err_bit_o` are zero.
- R2: A `start_i` pulse with `addr_i[8:0]==0` sets `busy_o` from the next cycle, restarts at slot 0 and clears the running parity. With any other address `busy_o` is 0 from the next cycle. While idle, byte transfers change no slot.
- R3: A block code is 24 bits. Bits [5:0] are column pairs: bit 2k is the XOR of all data bits whose position inside the byte has bit k clear, and bit 2k+1 covers those with bit k set, for k=0..2. Bits [23:6] are line pairs: bit 6+2j is the XOR of all bits of bytes whose block index has bit j clear, and bit 7+2j covers those with bit j set, for j=0..8.
- R4: The 512th accepted byte of a block closes it. Slot n of `code_o` (bits [24n+23:24n]) holds that block's code one cycle later, and the next byte starts block n+1 from zero parity.
- R5: A byte with `last_i` high closes the current block early: its code covers only the bytes received, it goes into the current slot, and `busy_o` drops in the next cycle.
- R6: After the fourth block closes, `busy_o` drops, and further bytes do not alter any slot.
- R7: A check (`chk_valid_i`) whose `chk_code_i` equals the stored code of block `chk_blk_i` sets that block's status field (bits [2b+1:2b] of `status_o`) to 0 one cycle later.
- R8: If the syndrome (stored XOR checked code) has exactly one bit set in every one of the 12 pairs, the status is 1. `err_byte_o` is set to the odd line bits (bit 7+2j gives byte-index bit j). `err_bit_o` is set to the odd column bits (bit 2k+1 gives bit k). The location outputs are loaded from the syndrome on every check.
- R9: A syndrome with exactly one bit set gives status 2 (error in the code itself).
- R10: Any other nonzero syndrome gives status 3 (uncorrectable). A check updates only the addressed block's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Read or write command issued (one-cycle pulse) |
| addr_i | input | ADDR_W | Flash byte address of the command |
| byte_valid_i | input | 1 | A data byte transfers this cycle |
| byte_i | input | 8 | Transferred data byte |
| last_i | input | 1 | This byte is the final transfer of the page |
| chk_valid_i | input | 1 | A read-back code is presented for checking |
| chk_blk_i | input | IDX_W | Block index of the code being checked |
| chk_code_i | input | 24 | Code read back from the spare area |
| busy_o | output | 1 | Engine armed and accumulating |
| code_o | output | NBLK*24 | Stored block codes, slot n at bits [24n+23:24n] |
| status_o | output | NBLK*2 | Per-block check status (0 ok, 1 corrected, 2 code error, 3 uncorrectable) |
| err_byte_o | output | 9 | Byte index from the last check's syndrome |
| err_bit_o | output | 3 | Bit index from the last check's syndrome |

## Verification
A stale or miscounted byte counter shows on `code_o` one cycle after a block should close: either the slot fills late or the code is formed over the wrong line-parity indices. A corrupted running parity shows up in the same cycle as a wrong slot code. A misclassified syndrome appears in the addressed status field one cycle after the check. The location outputs shift in that same cycle if the pair-to-bit mapping is wrong. The bench keeps its own per-block byte queues and code arithmetic, and it compares every output on every clock, so any of these faults is reported within a cycle of its first visible effect.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int LINE_BITS = 9;
  localparam int BLK_BYTES = 1 << LINE_BITS;
  localparam int COL_BITS  = 3;
  localparam int CODE_W    = 2 * (LINE_BITS + COL_BITS);

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_FATAL = 2'd3
  } blk_status_e;
endpackage

// File: rtl/ecc_accum.sv
module ecc_accum
  import nand_ecc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 en_i,
  input  logic [7:0]           byte_i,
  input  logic [LINE_BITS-1:0] idx_i,
  output logic [CODE_W-1:0]    code_next_o
);
  localparam int LINE_OFS = 2 * COL_BITS;

  function automatic logic [7:0] hi_mask(int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction

  logic [CODE_W-1:0] acc_q, contrib;
  logic              row_par;

  assign row_par = ^byte_i;

  for (genvar k = 0; k < COL_BITS; k++) begin : g_col
    assign contrib[2*k]   = ^(byte_i & ~hi_mask(k));
    assign contrib[2*k+1] = ^(byte_i &  hi_mask(k));
  end

  for (genvar j = 0; j < LINE_BITS; j++) begin : g_line
    assign contrib[LINE_OFS+2*j]   = row_par & ~idx_i[j];
    assign contrib[LINE_OFS+2*j+1] = row_par &  idx_i[j];
  end

  assign code_next_o = acc_q ^ contrib;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (en_i)    acc_q <= code_next_o;
  end

  // R4
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_q == '0);
endmodule

// File: rtl/ecc_store.sv
module ecc_store
  import nand_ecc_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int IDX_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [CODE_W-1:0]      wr_code_i,
  output logic [NBLK*CODE_W-1:0] codes_o
);
  logic [CODE_W-1:0] slot_q [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      slot_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))        slot_q[g] <= wr_code_i;
    end
    assign codes_o[g*CODE_W +: CODE_W] = slot_q[g];
  end

  // R4
  slot_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_idx_i) < NBLK) |=> slot_q[$past(wr_idx_i)] == $past(wr_code_i));
endmodule

// File: rtl/ecc_check.sv
module ecc_check
  import nand_ecc_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int IDX_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   chk_valid_i,
  input  logic [IDX_W-1:0]       chk_blk_i,
  input  logic [CODE_W-1:0]      chk_code_i,
  input  logic [NBLK*CODE_W-1:0] codes_i,
  output logic [NBLK*2-1:0]      status_o,
  output logic [LINE_BITS-1:0]   err_byte_o,
  output logic [COL_BITS-1:0]    err_bit_o
);
  localparam int PAIRS = CODE_W / 2;

  logic [CODE_W-1:0]    ref_a [NBLK];
  logic [CODE_W-1:0]    syn;
  logic [PAIRS-1:0]     pair_x;
  logic [PAIRS-1:0]     hi_bits;
  logic                 blk_ok;
  blk_status_e          cls;
  blk_status_e          status_q [NBLK];
  logic [LINE_BITS-1:0] err_byte_q;
  logic [COL_BITS-1:0]  err_bit_q;

  for (genvar g = 0; g < NBLK; g++) begin : g_unpack
    assign ref_a[g]                = codes_i[g*CODE_W +: CODE_W];
    assign status_o[2*g +: 2]      = status_q[g];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_x[p]  = syn[2*p] ^ syn[2*p+1];
    assign hi_bits[p] = syn[2*p+1];
  end

  assign blk_ok = int'(chk_blk_i) < NBLK;
  assign syn    = blk_ok ? (ref_a[chk_blk_i] ^ chk_code_i) : '0;

  always_comb begin
    if (syn == '0)                 cls = ST_OK;
    else if (&pair_x)              cls = ST_FIXED;
    else if ($countones(syn) == 1) cls = ST_CODE;
    else                           cls = ST_FATAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBLK; i++) status_q[i] <= ST_OK;
      err_byte_q <= '0;
      err_bit_q  <= '0;
    end else if (chk_valid_i && blk_ok) begin
      status_q[chk_blk_i] <= cls;
      err_bit_q  <= hi_bits[COL_BITS-1:0];
      err_byte_q <= hi_bits[PAIRS-1:COL_BITS];
    end
  end

  assign err_byte_o = err_byte_q;
  assign err_bit_o  = err_bit_q;

  // R7
  clean_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && blk_ok && chk_code_i == ref_a[chk_blk_i])
      |=> status_q[$past(chk_blk_i)] == ST_OK);
  // R9
  code_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && blk_ok && $countones(ref_a[chk_blk_i] ^ chk_code_i) == 1)
      |=> status_q[$past(chk_blk_i)] == ST_CODE);
  // R10
  fatal_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && blk_ok && $countones(ref_a[chk_blk_i] ^ chk_code_i) == 2)
      |=> status_q[$past(chk_blk_i)] == ST_FATAL);
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NBLK   = 4,
  localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   byte_valid_i,
  input  logic [7:0]             byte_i,
  input  logic                   last_i,
  input  logic                   chk_valid_i,
  input  logic [IDX_W-1:0]       chk_blk_i,
  input  logic [CODE_W-1:0]      chk_code_i,
  output logic                   busy_o,
  output logic [NBLK*CODE_W-1:0] code_o,
  output logic [NBLK*2-1:0]      status_o,
  output logic [LINE_BITS-1:0]   err_byte_o,
  output logic [COL_BITS-1:0]    err_bit_o
);
  logic                 busy_q;
  logic [IDX_W-1:0]     slot_q;
  logic [LINE_BITS-1:0] cnt_q;
  logic                 aligned, fire, close, final_slot;
  logic [CODE_W-1:0]    code_next;
  logic                 unused_addr;

  assign unused_addr = ^addr_i[ADDR_W-1:LINE_BITS];
  assign aligned     = addr_i[LINE_BITS-1:0] == '0;
  assign fire        = busy_q && byte_valid_i && !start_i;
  assign final_slot  = slot_q == IDX_W'(NBLK - 1);
  assign close       = fire && (last_i || cnt_q == LINE_BITS'(BLK_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= aligned;
      slot_q <= '0;
      cnt_q  <= '0;
    end else if (fire) begin
      cnt_q <= close ? '0 : cnt_q + 1'b1;
      if (close) begin
        slot_q <= slot_q + 1'b1;
        if (last_i || final_slot) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;

  ecc_accum u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_i || close),
    .en_i        (fire),
    .byte_i      (byte_i),
    .idx_i       (cnt_q),
    .code_next_o (code_next)
  );

  ecc_store #(.NBLK(NBLK), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (close),
    .wr_idx_i  (slot_q),
    .wr_code_i (code_next),
    .codes_o   (code_o)
  );

  ecc_check #(.NBLK(NBLK), .IDX_W(IDX_W)) u_check (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chk_valid_i (chk_valid_i),
    .chk_blk_i   (chk_blk_i),
    .chk_code_i  (chk_code_i),
    .codes_i     (code_o),
    .status_o    (status_o),
    .err_byte_o  (err_byte_o),
    .err_bit_o   (err_bit_o)
  );

  // R2
  arm_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && aligned) |=> busy_o);
  // R2
  skip_unaligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !aligned) |=> !busy_o);
  // R5
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && byte_valid_i && last_i && !start_i) |=> !busy_o);
  // R6
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(code_o));
endmodule

// File: tb/tb_nand_ecc_engine.sv
module tb_nand_ecc_engine;
  localparam int NBLK = 4;
  localparam int CW   = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       addr = '0;
  logic              bvalid = 1'b0;
  logic [7:0]        bdata = '0;
  logic              last = 1'b0;
  logic              cvalid = 1'b0;
  logic [1:0]        cblk = '0;
  logic [CW-1:0]     ccode = '0;
  logic              busy;
  logic [NBLK*CW-1:0] code;
  logic [NBLK*2-1:0] status;
  logic [8:0]        err_byte;
  logic [2:0]        err_bit;

  nand_ecc_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .byte_valid_i(bvalid), .byte_i(bdata), .last_i(last),
    .chk_valid_i(cvalid), .chk_blk_i(cblk), .chk_code_i(ccode),
    .busy_o(busy), .code_o(code), .status_o(status),
    .err_byte_o(err_byte), .err_bit_o(err_bit)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit run = 1'b0;

  // reference model state
  bit          m_busy = 0;
  int          m_slot = 0;
  logic [7:0]  m_q[$];
  logic [CW-1:0] m_code [NBLK];
  logic [1:0]  m_stat [NBLK];
  logic [8:0]  m_ebyte = '0;
  logic [2:0]  m_ebit = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] ref_code(logic [7:0] q[$]);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < q.size(); i++)
      for (int b = 0; b < 8; b++)
        if (q[i][b]) begin
          for (int k = 0; k < 3; k++) c[2*k + ((b >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 9; j++) c[6 + 2*j + ((i >> j) & 1)] ^= 1'b1;
        end
    return c;
  endfunction

  function automatic logic [CW-1:0] single_err(int byte_ix, int bit_ix);
    logic [CW-1:0] s = '0;
    for (int k = 0; k < 3; k++) s[2*k + ((bit_ix >> k) & 1)] = 1'b1;
    for (int j = 0; j < 9; j++) s[6 + 2*j + ((byte_ix >> j) & 1)] = 1'b1;
    return s;
  endfunction

  task automatic model_step();
    if (start) begin
      m_busy = (addr[8:0] == 0);
      m_slot = 0;
      m_q.delete();
    end else if (m_busy && bvalid) begin
      m_q.push_back(bdata);
      if (m_q.size() == 512 || last) begin
        m_code[m_slot] = ref_code(m_q);
        m_q.delete();
        if (last || m_slot == NBLK - 1) m_busy = 0;
        m_slot++;
      end
    end
    if (cvalid) begin
      logic [CW-1:0] s;
      bit all_pairs;
      s = m_code[cblk] ^ ccode;
      all_pairs = 1;
      for (int p = 0; p < 12; p++) if (s[2*p] == s[2*p+1]) all_pairs = 0;
      if (s == 0)                 m_stat[cblk] = 2'd0;
      else if (all_pairs)         m_stat[cblk] = 2'd1;
      else if ($countones(s) == 1) m_stat[cblk] = 2'd2;
      else                        m_stat[cblk] = 2'd3;
      for (int j = 0; j < 9; j++) m_ebyte[j] = s[7 + 2*j];
      for (int k = 0; k < 3; k++) m_ebit[k] = s[2*k + 1];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (run) begin
    chk("R2 busy", 32'(busy), 32'(m_busy));
    for (int b = 0; b < NBLK; b++) begin
      chk("R3 code", 32'(code[b*CW +: CW]), 32'(m_code[b]));
      chk("R7 status", 32'(status[2*b +: 2]), 32'(m_stat[b]));
    end
    chk("R8 err_byte", 32'(err_byte), 32'(m_ebyte));
    chk("R8 err_bit", 32'(err_bit), 32'(m_ebit));
  end

  task automatic do_start(logic [31:0] a);
    start = 1; addr = a; tick(); start = 0;
  endtask

  task automatic send(int n, bit with_last, int seed);
    for (int i = 0; i < n; i++) begin
      bvalid = 1; bdata = 8'((i * 37 + seed * 11 + (i >> 5)) & 8'hff);
      last = with_last && (i == n - 1);
      tick();
      if (i % 7 == 3) begin bvalid = 0; last = 0; tick(); end
    end
    bvalid = 0; last = 0;
  endtask

  task automatic do_check(int blk, logic [CW-1:0] c);
    cvalid = 1; cblk = 2'(blk); ccode = c; tick(); cvalid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [CW-1:0] saved;
    for (int b = 0; b < NBLK; b++) begin m_code[b] = '0; m_stat[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run = 1;
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 codes", 32'(|code), 0);
    chk("R1 status", 32'(status), 0);

    // R2 unaligned start stays idle, bytes ignored
    do_start(32'h0000_0104);
    chk("R2 unaligned idle", 32'(busy), 0);
    send(20, 0, 1);
    chk("R2 no code update", 32'(|code), 0);

    // R4 full four-block page
    do_start(32'h0001_0200);
    chk("R2 aligned arms", 32'(busy), 1);
    send(2048, 1, 2);
    for (int b = 0; b < NBLK; b++) chk("R4 slot code", 32'(code[b*CW +: CW]), 32'(m_code[b]));
    chk("R4 page done", 32'(busy), 0);

    // R7 clean, R8 single-bit, R9 code bit, R10 double bit
    do_check(0, code[0 +: CW]);
    chk("R7 clean block", 32'(status[1:0]), 0);
    do_check(1, code[CW +: CW] ^ single_err(300, 5));
    chk("R8 corrected", 32'(status[3:2]), 1);
    chk("R8 byte loc", 32'(err_byte), 300);
    chk("R8 bit loc", 32'(err_bit), 5);
    do_check(2, code[2*CW +: CW] ^ 24'h00_0080);
    chk("R9 code error", 32'(status[5:4]), 2);
    do_check(3, code[3*CW +: CW] ^ 24'h00_0003);
    chk("R10 uncorrectable", 32'(status[7:6]), 3);
    chk("R10 others kept", 32'(status[3:0]), 32'h4);
    do_check(1, code[CW +: CW] ^ single_err(0, 0) ^ single_err(511, 7));
    chk("R10 two flips", 32'(status[3:2]), 3);

    // R5 short page closes early
    do_start(32'h0000_0400);
    send(100, 1, 3);
    chk("R5 short block idle", 32'(busy), 0);
    chk("R5 partial code", 32'(code[0 +: CW]), 32'(m_code[0]));

    // R6 overrun past four blocks
    do_start(32'h0000_0000);
    send(2048, 0, 4);
    saved = code[3*CW +: CW];
    chk("R6 idle after four", 32'(busy), 0);
    send(9, 0, 5);
    chk("R6 slot held", 32'(code[3*CW +: CW]), 32'(saved));

    // R2 unaligned start aborts an active page
    do_start(32'h0000_0000);
    send(10, 0, 6);
    do_start(32'h0000_0001);
    chk("R2 abort", 32'(busy), 0);
    send(600, 0, 7);

    repeat (2) tick();
    run = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule